// File: doc/BRIEF.md
# Serial Flash Status and Protection Controller

This block holds the status byte of a small serial flash with a 64 KB array and rules on every decoded command whether the device may carry it out. It sits after the serial command decoder. The decoder hands over one strobe per command, carrying a 4-bit opcode, a 24-bit address and a data byte for status writes. The block answers one cycle later with a response strobe and an accept flag. Downstream logic starts an array operation only on an accepted command.

Acceptance depends on several pieces of state. The write-enable latch must be set. The target address must lie outside the region chosen by the three block-protect bits. A chip erase needs all protect bits clear. A status-register write is refused when the status-protect bit is set and the write-protect pin is low. Every command except wake-up is refused in deep power-down. The array operation is stood in for by an internal timer: an accepted status write, program or erase raises the busy bit for `BUSY_CYCLES` cycles. While busy, only a status read is accepted. When the timer runs out, the write-enable latch clears.

Top module: `flash_guard`

## Requirements
- R1: After synchronous reset, and after a reset applied during an operation, `status_o` is 0x00, `busy_o` is 0 and `resp_valid` is 0.
- R2: Opcodes are: 0 read status, 1 write enable, 2 write disable, 3 status write, 4 read, 5 page program, 6 sector erase, 7 block erase, 8 chip erase, 9 enter deep power-down, 10 wake. Every strobe gets `resp_valid` one cycle later. Write enable sets bit 1 (WEL) and write disable clears it. Undefined codes are rejected.
- R3: With WEL at 0, status write, program and the three erases are rejected and the status byte is unchanged.
- R4: Bits 4..2 of the status byte form the protect field. 000 guards nothing. 001 guards 0x0000–0xDFFF, 010 guards 0x0000–0xBFFF, 011 guards 0x0000–0x7FFF, and any value with bit 4 set guards 0x0000–0xFFFF.
- R5: Page program, sector erase and block erase are rejected when the address falls in the guarded range, or when any address bit above bit 15 is set.
- R6: Chip erase is accepted only when the protect field is 000.
- R7: A status write is rejected when bit 7 (status protect) is 1 and `wp_n` is 0. The protect field is then left unchanged.
- R8: An accepted status write copies data bits 7 and 4..2 only. Bits 6..5 always read 0, and data bits 1..0 do not affect WEL or bit 0.
- R9: An accepted status write, program or erase sets bit 0 (WIP) and `busy_o` for exactly `BUSY_CYCLES` cycles, starting in the response cycle. In the cycle WIP falls, WEL is 0.
- R10: While WIP is 1, every command except read status is rejected, including one that arrives in the last busy cycle.
- R11: After an accepted enter-deep-power-down, every command except wake is rejected and leaves the status byte unchanged until a wake is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 4 | Command opcode (R2) |
| cmd_addr | input | 24 | Target byte address |
| cmd_data | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| status_o | output | 8 | Status byte: 7 status protect, 6..5 zero, 4..2 protect field, 1 WEL, 0 WIP |
| resp_valid | output | 1 | Response strobe, one cycle after `cmd_valid` |
| resp_accept | output | 1 | Command accepted, valid with `resp_valid` |
| busy_o | output | 1 | Array operation in progress |

## Verification
Two events can land in the same cycle: the timer finishing an operation, and a new command being judged against the still-set busy bit. The bench counts the busy cycles of a program and strikes a write enable in exactly the last one. It expects that command to be rejected, and expects busy and WEL to read 0 in the response cycle. A second write enable, presented one cycle later, must then be accepted. Status reads and write enables sent earlier in the same window check that only the status read gets through while the operation runs.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [3:0] {
        OP_RDSR   = 4'd0,
        OP_WREN   = 4'd1,
        OP_WRDI   = 4'd2,
        OP_WRSR   = 4'd3,
        OP_READ   = 4'd4,
        OP_PROG   = 4'd5,
        OP_SERASE = 4'd6,
        OP_BERASE = 4'd7,
        OP_CERASE = 4'd8,
        OP_SLEEP  = 4'd9,
        OP_WAKE   = 4'd10
    } op_e;

    // Status byte layout; a neighbour reads these positions.
    typedef struct packed {
        logic       srp;
        logic [1:0] rsvd;
        logic [2:0] bp;
        logic       wel;
        logic       wip;
    } stat_t;

    // Bits a status write may change: SRP and the protect field.
    localparam logic [7:0] WR_MASK = 8'h9C;

    function automatic logic op_modifies(logic [3:0] op);
        return (op == OP_WRSR) || (op == OP_PROG) || (op == OP_SERASE) ||
               (op == OP_BERASE) || (op == OP_CERASE);
    endfunction

    function automatic logic op_addressed(logic [3:0] op);
        return (op == OP_PROG) || (op == OP_SERASE) || (op == OP_BERASE);
    endfunction

    // Number of guarded bytes from address zero upward.
    function automatic int unsigned guard_bytes(logic [2:0] bp, int unsigned array_bytes);
        int unsigned sixteenth;
        sixteenth = array_bytes / 16;
        if (bp[2])
            return array_bytes;
        case (bp[1:0])
            2'b01:   return sixteenth * 14;
            2'b10:   return sixteenth * 12;
            2'b11:   return sixteenth * 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/fsp_prot_decode.sv
module fsp_prot_decode #(
    parameter int unsigned ARRAY_BYTES = 65536,
    parameter int unsigned ADDR_W      = 24
) (
    input  logic [2:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              guarded
);
    import fsp_pkg::*;

    localparam int unsigned AW = $clog2(ARRAY_BYTES);

    logic [AW:0] span;
    logic        below_span;
    logic        beyond_array;

    always_comb span = (AW+1)'(guard_bytes(bp, ARRAY_BYTES));

    assign below_span = ({1'b0, addr[AW-1:0]} < span);

    generate
        if (ADDR_W > AW) begin : g_upper
            assign beyond_array = |addr[ADDR_W-1:AW];
        end else begin : g_flat
            assign beyond_array = 1'b0;
        end
    endgenerate

    assign guarded = below_span || beyond_array;

endmodule

// File: rtl/fsp_busy_timer.sv
module fsp_busy_timer #(
    parameter int unsigned BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic finish
);
    localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
        end else if (start && !busy) begin
            busy <= 1'b1;
            left <= CW'(BUSY_CYCLES);
        end else if (busy) begin
            if (left == CW'(1))
                busy <= 1'b0;
            left <= left - CW'(1);
        end
    end

    assign finish = busy && (left == CW'(1));

endmodule

// File: rtl/fsp_cmd_judge.sv
module fsp_cmd_judge (
    input  logic [3:0] op,
    input  logic       wip,
    input  logic       wel,
    input  logic       srp,
    input  logic [2:0] bp,
    input  logic       wp_n,
    input  logic       asleep,
    input  logic       guarded,
    output logic       accept
);
    import fsp_pkg::*;

    logic hw_locked;
    assign hw_locked = srp && !wp_n;

    always_comb begin
        accept = 1'b0;
        if (asleep) begin
            accept = (op == OP_WAKE);
        end else if (wip) begin
            accept = (op == OP_RDSR);
        end else begin
            case (op)
                OP_RDSR, OP_READ, OP_WREN, OP_WRDI, OP_SLEEP, OP_WAKE:
                    accept = 1'b1;
                OP_WRSR:
                    accept = wel && !hw_locked;
                OP_PROG, OP_SERASE, OP_BERASE:
                    accept = wel && !guarded;
                OP_CERASE:
                    accept = wel && (bp == 3'b000);
                default:
                    accept = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/flash_guard.sv
module flash_guard #(
    parameter int unsigned ARRAY_BYTES = 65536,
    parameter int unsigned BUSY_CYCLES = 8,
    parameter int unsigned ADDR_W      = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              wp_n,
    output logic [7:0]        status_o,
    output logic              resp_valid,
    output logic              resp_accept,
    output logic              busy_o
);
    import fsp_pkg::*;

    logic [7:0] prot_q;
    logic       wel_q;
    logic       asleep_q;
    logic       wip;
    logic       op_done;
    logic       guarded;
    logic       accept;
    logic       take;
    stat_t      stat;

    assign stat = '{srp: prot_q[7], rsvd: 2'b00, bp: prot_q[4:2], wel: wel_q, wip: wip};

    fsp_prot_decode #(.ARRAY_BYTES(ARRAY_BYTES), .ADDR_W(ADDR_W)) i_decode (
        .bp      (stat.bp),
        .addr    (cmd_addr),
        .guarded (guarded)
    );

    fsp_cmd_judge i_judge (
        .op      (cmd_op),
        .wip     (stat.wip),
        .wel     (stat.wel),
        .srp     (stat.srp),
        .bp      (stat.bp),
        .wp_n    (wp_n),
        .asleep  (asleep_q),
        .guarded (guarded),
        .accept  (accept)
    );

    assign take = cmd_valid && accept;

    fsp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (take && op_modifies(cmd_op)),
        .busy   (wip),
        .finish (op_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prot_q      <= 8'h00;
            wel_q       <= 1'b0;
            asleep_q    <= 1'b0;
            resp_valid  <= 1'b0;
            resp_accept <= 1'b0;
        end else begin
            resp_valid  <= cmd_valid;
            resp_accept <= take;
            if (op_done)
                wel_q <= 1'b0;
            if (take) begin
                case (cmd_op)
                    OP_WREN:  wel_q    <= 1'b1;
                    OP_WRDI:  wel_q    <= 1'b0;
                    OP_WRSR:  prot_q   <= (prot_q & ~WR_MASK) | (cmd_data & WR_MASK);
                    OP_SLEEP: asleep_q <= 1'b1;
                    OP_WAKE:  asleep_q <= 1'b0;
                    default:  ;
                endcase
            end
        end
    end

    assign status_o = stat;
    assign busy_o   = wip;

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic       wp_n,
    input logic [7:0] status_o,
    input logic       resp_valid,
    input logic       resp_accept
);
    import fsp_pkg::*;

    // R2
    resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> resp_valid);

    // R3
    wel_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !status_o[1] && op_modifies(cmd_op)) |=> (resp_valid && !resp_accept));

    // R6
    chip_rule_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_CERASE && status_o[4:2] != 3'b000) |=> !resp_accept);

    // R7
    hw_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_WRSR && status_o[7] && !wp_n) |=> (!resp_accept && $stable(status_o[7:2])));

    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[6:5] == 2'b00);

    // R9
    done_clears_wel_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[0]) |-> !status_o[1]);

    // R10
    busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && status_o[0] && cmd_op != OP_RDSR) |=> !resp_accept);

    // R2
    no_phantom_accept_chk: assert property (@(posedge clk) disable iff (rst)
        resp_accept |-> resp_valid);

endmodule

bind flash_guard flash_guard_chk i_chk (.*);

// File: tb/test_flash_guard.sv
module test_flash_guard;
    localparam int BUSY = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [23:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        wp_n = 1'b1;
    logic [7:0]  status_o;
    logic        resp_valid;
    logic        resp_accept;
    logic        busy_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    flash_guard #(.BUSY_CYCLES(BUSY)) i_flash_guard (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n),
        .status_o(status_o), .resp_valid(resp_valid),
        .resp_accept(resp_accept), .busy_o(busy_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [3:0]  op;
        logic [23:0] addr;
        logic [7:0]  data;
        logic        wpn;
        logic        acc;
        logic [7:0]  st;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [0:NV-1] = '{
        {4'd3,  4'd5,  24'h008000, 8'h00, 1'b1, 1'b0, 8'h00}, // R3 program without WEL
        {4'd2,  4'd1,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h02}, // R2 write enable
        {4'd2,  4'd2,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h00}, // R2 write disable
        {4'd3,  4'd3,  24'h000000, 8'h0C, 1'b1, 1'b0, 8'h00}, // R3 status write without WEL
        {4'd2,  4'd1,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h02},
        {4'd9,  4'd3,  24'h000000, 8'h0C, 1'b1, 1'b1, 8'h0C}, // R9 WEL clears after write
        {4'd2,  4'd1,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h0E},
        {4'd5,  4'd5,  24'h007FFF, 8'h00, 1'b1, 1'b0, 8'h0E}, // R5 top of 32 KB guard
        {4'd4,  4'd5,  24'h008000, 8'h00, 1'b1, 1'b1, 8'h0C}, // R4 first free byte
        {4'd2,  4'd1,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h0E},
        {4'd6,  4'd8,  24'h000000, 8'h00, 1'b1, 1'b0, 8'h0E}, // R6 chip erase refused
        {4'd4,  4'd3,  24'h000000, 8'h04, 1'b1, 1'b1, 8'h04}, // R4 set 56 KB guard
        {4'd2,  4'd1,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h06},
        {4'd5,  4'd6,  24'h00DFFF, 8'h00, 1'b1, 1'b0, 8'h06}, // R5 top of 56 KB guard
        {4'd4,  4'd6,  24'h00E000, 8'h00, 1'b1, 1'b1, 8'h04}, // R4 above 56 KB guard
        {4'd2,  4'd1,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h06},
        {4'd5,  4'd7,  24'h010000, 8'h00, 1'b1, 1'b0, 8'h06}, // R5 outside array
        {4'd8,  4'd3,  24'h000000, 8'h90, 1'b1, 1'b1, 8'h90}, // R8 SRP and whole guard
        {4'd2,  4'd1,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h92},
        {4'd4,  4'd7,  24'h00FFFF, 8'h00, 1'b1, 1'b0, 8'h92}, // R4 bit 4 guards all
        {4'd7,  4'd3,  24'h000000, 8'h00, 1'b0, 1'b0, 8'h92}, // R7 hardware lock
        {4'd8,  4'd3,  24'h000000, 8'h63, 1'b1, 1'b1, 8'h00}, // R8 reserved/WEL/WIP data ignored
        {4'd2,  4'd1,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h02},
        {4'd6,  4'd8,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h00}, // R6 chip erase allowed
        {4'd2,  4'd1,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h02},
        {4'd11, 4'd9,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h02}, // R11 enter power-down
        {4'd11, 4'd0,  24'h000000, 8'h00, 1'b1, 1'b0, 8'h02}, // R11 status read refused
        {4'd11, 4'd2,  24'h000000, 8'h00, 1'b1, 1'b0, 8'h02}, // R11 write disable ignored
        {4'd11, 4'd10, 24'h000000, 8'h00, 1'b1, 1'b1, 8'h02}, // R11 wake
        {4'd2,  4'd2,  24'h000000, 8'h00, 1'b1, 1'b1, 8'h00},
        {4'd2,  4'd15, 24'h000000, 8'h00, 1'b1, 1'b0, 8'h00}  // R2 undefined code
    };

    task automatic check(input bit ok, input string req, input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the response edge.
    task automatic issue(input logic [3:0] op, input logic [23:0] addr, input logic [7:0] data);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        cmd_data  = data;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int busy_seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(status_o == 8'h00, "R1 status", status_o, 8'h00);
        check(!busy_o && !resp_valid, "R1 idle", {busy_o, resp_valid}, 0);

        for (int i = 0; i < NV; i++) begin
            wp_n = VEC[i].wpn;
            issue(VEC[i].op, VEC[i].addr, VEC[i].data);
            check(resp_valid && resp_accept == VEC[i].acc,
                  $sformatf("R%0d accept vec %0d", VEC[i].req, i),
                  {resp_valid, resp_accept}, {1'b1, VEC[i].acc});
            wait_idle();
            check(status_o == VEC[i].st,
                  $sformatf("R%0d status vec %0d", VEC[i].req, i),
                  status_o, VEC[i].st);
        end
        wp_n = 1'b1;

        // R9 busy window length and R10 gating inside it
        issue(4'd1, 24'h0, 8'h00);
        issue(4'd5, 24'h001234, 8'h00);
        check(resp_accept && busy_o && status_o == 8'h03, "R9 busy starts", status_o, 8'h03);
        busy_seen = 1;
        issue(4'd0, 24'h0, 8'h00);
        busy_seen++;
        check(resp_accept && busy_o, "R10 status read while busy", resp_accept, 1);
        issue(4'd1, 24'h0, 8'h00);
        busy_seen++;
        check(!resp_accept && busy_o, "R10 write enable while busy", resp_accept, 0);
        repeat (BUSY - busy_seen) begin
            @(negedge clk);
            if (busy_o) busy_seen++;
        end
        check(busy_o && busy_seen == BUSY, "R9 busy length", busy_seen, BUSY);
        // In the last busy cycle: command must be refused, completion clears WIP/WEL
        issue(4'd1, 24'h0, 8'h00);
        check(resp_valid && !resp_accept, "R10 last busy cycle", resp_accept, 0);
        check(!busy_o && status_o == 8'h00, "R9 completion", status_o, 8'h00);
        issue(4'd1, 24'h0, 8'h00);
        check(resp_accept && status_o == 8'h02, "R10 accepted after busy", status_o, 8'h02);

        // R1 reset during an operation
        issue(4'd3, 24'h0, 8'h0C);
        check(busy_o, "R1 op started", busy_o, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(status_o == 8'h00 && !busy_o && !resp_valid, "R1 mid-op reset", status_o, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule